// File: doc/BRIEF.md
# Source-Routed Packet Switch with Header Rotation

This block is a four-port packet switch for serialized on-chip links. A packet is four 20-bit phits long. The first phit carries a 16-bit route header in its upper bits, and that header is a list of 2-bit output port indexes. The index that applies to the current switch sits at the top of the header. The switch holds no routing table and no topology state. It reads the top index of each arriving header and connects the input to the output that index names. That connection lasts for all four phits of the packet.

As the first phit passes through, the header is rotated. It is shifted left by one index, and the index of the arrival port, with its two bits swapped, is placed at the bottom. After a packet has crossed a chain of such switches, reversing the bit order of the whole header gives the route back to the sender.

Each output has its own round-robin arbiter. An input that loses arbitration keeps its packet and waits; it never drops a phit. A source may also pause in the middle of a packet. The output phits are registered.

Top module: `srcroute_switch`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every `out_valid` bit and every `in_ready` bit is 0.
- R2: A packet whose header's top two bits (phit bits 19:18) equal d leaves on output d. All four phits leave in their original order. Phits 1 to 3 and bits 3:0 of phit 0 are unchanged.
- R3: Bits 19:4 of the outgoing first phit equal the incoming header bits 17:4 followed by the arrival port index with its two bits swapped. For example, input 1 (binary 01) is appended as 10.
- R4: When an idle output receives a header from a single input, `in_ready` of that input rises one cycle after the header is first presented. The first phit appears on the output two cycles after the header is first presented.
- R5: Each output arbitrates by round robin. Among the requesting inputs, the first one above the most recently granted input wins, wrapping from 3 to 0. After reset, the search starts at input 0.
- R6: A granted connection is held until four phits have been accepted. While it is held, no phit from another input appears on that output. A losing input sees `in_ready` low and later delivers its packet intact.
- R7: A header whose top index equals the arrival port's own index is granted, so loopback works.
- R8: Packets to different outputs are forwarded at the same time. Each reaches its output with the latency given in R4.
- R9: If the source drops `in_valid` in the middle of a packet, `in_ready` stays high and the connection is kept. The remaining phits follow when the source resumes, and the packet arrives intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Per-input phit valid |
| in_data | input | 80 | Input phits, input i at bits [20*i+19 : 20*i] |
| in_ready | output | 4 | Per-input accept; a phit is taken when valid and ready are both high |
| out_valid | output | 4 | Per-output phit valid |
| out_data | output | 80 | Output phits, output o at bits [20*o+19 : 20*o] |

## Verification
The hardest situation to reach from the ports is round robin that is visibly different from fixed priority. To get there, the pointer of one output must first be moved by a contended pair of packets. A second pair is then sent whose order of service only rotation can explain. The bench does this on output 3. It first sends inputs 0 and 1 together, so input 1 is the last one granted. It then sends inputs 0 and 3 together and expects input 3 to win. A mid-packet source pause is forced by a driver option that drops valid for three cycles after the second phit, and the bench samples `in_ready` during those three cycles.

// File: rtl/srcroute_switch.sv
module srcroute_switch #(
  parameter int IDX_W     = 2,
  parameter int PHIT_W    = 20,
  parameter int HDR_W     = 16,
  parameter int PKT_PHITS = 4,
  localparam int NPORT    = 1 << IDX_W,
  localparam int CNT_W    = $clog2(PKT_PHITS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        in_valid,
  input  logic [NPORT*PHIT_W-1:0] in_data,
  output logic [NPORT-1:0]        in_ready,
  output logic [NPORT-1:0]        out_valid,
  output logic [NPORT*PHIT_W-1:0] out_data
);

  function automatic logic [IDX_W-1:0] swap_bits(input logic [IDX_W-1:0] v);
    for (int b = 0; b < IDX_W; b++) swap_bits[b] = v[IDX_W-1-b];
  endfunction

  logic [NPORT-1:0]       busy;
  logic [NPORT*IDX_W-1:0] owner;
  logic [NPORT-1:0]       bound;

  always_comb begin
    bound = '0;
    for (int o = 0; o < NPORT; o++)
      if (busy[o]) bound[owner[o*IDX_W +: IDX_W]] = 1'b1;
  end

  assign in_ready = bound;

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic              busy_q;
    logic [IDX_W-1:0]  own_q, ptr_q, gnt;
    logic [CNT_W-1:0]  cnt_q;
    logic [NPORT-1:0]  req;
    logic              gnt_ok, acc, vld_q;
    logic [PHIT_W-1:0] sel, fwd, dat_q;

    always_comb begin
      for (int i = 0; i < NPORT; i++)
        req[i] = in_valid[i] & ~bound[i] &
                 (in_data[i*PHIT_W + PHIT_W - 1 -: IDX_W] == IDX_W'(o));
    end

    always_comb begin
      logic [IDX_W-1:0] c;
      gnt_ok = 1'b0;
      gnt    = ptr_q;
      for (int off = 1; off <= NPORT; off++) begin
        c = ptr_q + IDX_W'(off);
        if (!gnt_ok && req[c]) begin
          gnt_ok = 1'b1;
          gnt    = c;
        end
      end
    end

    assign sel = in_data[int'(own_q)*PHIT_W +: PHIT_W];
    assign acc = busy_q & in_valid[own_q];
    assign fwd = (cnt_q == '0)
               ? {sel[PHIT_W-IDX_W-1 -: HDR_W-IDX_W], swap_bits(own_q), sel[PHIT_W-HDR_W-1:0]}
               : sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        own_q  <= '0;
        ptr_q  <= IDX_W'(NPORT-1);
        cnt_q  <= '0;
        vld_q  <= 1'b0;
        dat_q  <= '0;
      end else begin
        vld_q <= acc;
        if (acc) dat_q <= fwd;
        if (!busy_q) begin
          if (gnt_ok) begin
            busy_q <= 1'b1;
            own_q  <= gnt;
            ptr_q  <= gnt;
            cnt_q  <= '0;
          end
        end else if (acc) begin
          if (cnt_q == CNT_W'(PKT_PHITS-1)) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end

    assign busy[o]                      = busy_q;
    assign owner[o*IDX_W +: IDX_W]      = own_q;
    assign out_valid[o]                 = vld_q;
    assign out_data[o*PHIT_W +: PHIT_W] = dat_q;
  end

endmodule

module srcroute_switch_chk #(
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] in_valid,
  input logic [NPORT-1:0] in_ready,
  input logic [NPORT-1:0] out_valid
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0 && in_ready == '0));

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(in_ready & ~in_valid) & ~in_ready) == '0));

  // R2
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_valid) == $countones($past(in_valid & in_ready))));

  // R4
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_ready & ~$past(in_ready) & ~$past(in_valid)) == '0));

endmodule

bind srcroute_switch srcroute_switch_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid)
);

// File: tb/sim_srcroute_switch.sv
`timescale 1ns/1ps
module sim_srcroute_switch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  v = '0;
  logic [19:0] d [4];
  logic [79:0] in_data;
  logic [3:0]  in_ready, out_valid;
  logic [79:0] out_data;

  int checks = 0, errors = 0, cyc = 0;
  logic [19:0] rx [4][16];
  int rx_n [4];
  int rx_cyc [4][4];
  int sent_cyc [4];
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign in_data = {d[3], d[2], d[1], d[0]};

  srcroute_switch u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  always @(negedge clk) begin
    for (int o = 0; o < 4; o++)
      if (out_valid[o] && rx_n[o] < 16) begin
        rx[o][rx_n[o]] = out_data[o*20 +: 20];
        if (rx_n[o] % 4 == 0) rx_cyc[o][rx_n[o]/4] = cyc;
        rx_n[o]++;
      end
  end

  function automatic logic [1:0] rv(input int s);
    logic [1:0] t = 2'(s);
    return {t[0], t[1]};
  endfunction

  function automatic logic [19:0] pay(input logic [19:0] seed, input int k);
    return seed + 20'(k * 20'h11111);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_rx();
    for (int o = 0; o < 4; o++) rx_n[o] = 0;
  endtask

  task automatic send(input int p, input logic [15:0] hdr, input logic [19:0] seed, input int gap_at);
    int k = 0;
    bit rdy;
    sent_cyc[p] = cyc;
    while (k < 4) begin
      d[p] = (k == 0) ? {hdr, seed[3:0]} : pay(seed, k);
      v[p] = 1'b1;
      rdy = in_ready[p];
      @(negedge clk);
      if (rdy) begin
        k++;
        if (k == gap_at + 1 && k < 4) begin
          v[p] = 1'b0;
          for (int g = 0; g < 3; g++) begin
            check(in_ready[p] == 1'b1, "R9 ready kept during source pause", in_ready[p], 1);
            @(negedge clk);
          end
        end
      end
    end
    v[p] = 1'b0;
  endtask

  task automatic check_pkt(input int o, input int n, input int src, input logic [15:0] hdr,
                           input logic [19:0] seed, input int lat, input string tag);
    logic [19:0] e;
    check(rx_n[o] >= n*4 + 4, {tag, " phit count"}, rx_n[o], n*4 + 4);
    if (rx_n[o] < n*4 + 4) return;
    e = {hdr[13:0], rv(src), seed[3:0]};
    check(rx[o][n*4] == e, {tag, " R3 rewritten first phit"}, rx[o][n*4], e);
    for (int k = 1; k < 4; k++)
      check(rx[o][n*4+k] == pay(seed, k), {tag, " R2 payload phit"}, rx[o][n*4+k], pay(seed, k));
    if (lat >= 0)
      check(rx_cyc[o][n] - sent_cyc[src] == lat, {tag, " R4 latency"}, rx_cyc[o][n] - sent_cyc[src], lat);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check(out_valid == 4'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 4'b0, "R1 in_ready in reset", in_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    check(out_valid == 4'b0, "R1 out_valid after release", out_valid, 0);
    check(in_ready == 4'b0, "R1 in_ready after release", in_ready, 0);
    @(negedge clk);
  endtask

  task automatic t_single();
    clear_rx();
    send(1, 16'hB123, 20'h5A5A1, 9);
    settle();
    check_pkt(2, 0, 1, 16'hB123, 20'h5A5A1, 2, "R2 in1->out2");
    check(rx_n[0] + rx_n[1] + rx_n[3] == 0, "R2 no stray output", rx_n[0] + rx_n[1] + rx_n[3], 0);
  endtask

  task automatic t_contend();
    clear_rx();
    fork
      send(0, 16'h4001, 20'h10000, 9);
      send(1, 16'h7FFE, 20'h20000, 9);
      send(3, 16'h5555, 20'h30000, 9);
      begin
        repeat (3) @(negedge clk);
        check(in_ready == 4'b0001, "R6 losers held off", in_ready, 4'b0001);
      end
    join
    settle();
    check_pkt(1, 0, 0, 16'h4001, 20'h10000, 2, "R5 first in0");
    check_pkt(1, 1, 1, 16'h7FFE, 20'h20000, -1, "R5 then in1");
    check_pkt(1, 2, 3, 16'h5555, 20'h30000, -1, "R6 then in3 intact");
  endtask

  task automatic t_rotate();
    clear_rx();
    fork
      send(0, 16'hC0DE, 20'hA0000, 9);
      send(1, 16'hFACE, 20'hB0000, 9);
    join
    settle();
    check_pkt(3, 0, 0, 16'hC0DE, 20'hA0000, -1, "R5 out3 first in0");
    check_pkt(3, 1, 1, 16'hFACE, 20'hB0000, -1, "R5 out3 then in1");
    clear_rx();
    fork
      send(0, 16'hC111, 20'hC0000, 9);
      send(3, 16'hD222, 20'hD0000, 9);
    join
    settle();
    check_pkt(3, 0, 3, 16'hD222, 20'hD0000, -1, "R5 rotation in3 before in0");
    check_pkt(3, 1, 0, 16'hC111, 20'hC0000, -1, "R5 rotation in0 second");
  endtask

  task automatic t_parallel();
    clear_rx();
    fork
      send(0, 16'h4AAA, 20'h01234, 9);
      send(1, 16'h0BBB, 20'h05678, 9);
      send(2, 16'hCCCC, 20'h09ABC, 9);
      send(3, 16'h8DDD, 20'h0DEF0, 9);
    join
    settle();
    check_pkt(1, 0, 0, 16'h4AAA, 20'h01234, 2, "R8 in0->out1");
    check_pkt(0, 0, 1, 16'h0BBB, 20'h05678, 2, "R8 in1->out0");
    check_pkt(3, 0, 2, 16'hCCCC, 20'h09ABC, 2, "R8 in2->out3");
    check_pkt(2, 0, 3, 16'h8DDD, 20'h0DEF0, 2, "R8 in3->out2");
  endtask

  task automatic t_loopback();
    clear_rx();
    send(2, 16'h9876, 20'h77777, 9);
    settle();
    check_pkt(2, 0, 2, 16'h9876, 20'h77777, 2, "R7 loopback in2->out2");
  endtask

  task automatic t_pause();
    clear_rx();
    send(2, 16'h1357, 20'h24680, 1);
    settle();
    check_pkt(0, 0, 2, 16'h1357, 20'h24680, 2, "R9 paused packet");
    check(in_ready == 4'b0, "R9 released after fourth phit", in_ready, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin d[i] = '0; rx_n[i] = 0; sent_cyc[i] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_contend();
    t_rotate();
    t_parallel();
    t_loopback();
    t_pause();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule